// File: doc/BRIEF.md
# SPI Chip-Select Sequencer

This block frames every word moved by an SPI shift engine. It sits between whatever issues words and the engine that shifts the bits. It selects one of several active-low chip-select lines. It waits a programmable number of clock cycles before it tells the engine to start. After the engine reports completion, it keeps the line low for a programmable time before it lets go. It can also add an idle gap before the next word may begin. With the keep option set, the line stays low from one word to the next. A word that follows on the same line then starts with no setup wait.

A handshake mode is also available. In this mode the sequencer does not start the engine until the slave pulls its active-low ready line low. If ready does not arrive within a programmed lead count plus a fixed character allowance, the sequencer gives up and raises a timeout pulse. After each word, ready must go back inactive within a programmed trail count. If it does not, the sequencer raises a desynchronisation pulse. In both error cases the word is still closed in an orderly way.

All delays are counted in cycles of the block clock. The per-word controls (line index, keep, gap enable) are captured when a word is accepted. The timing configuration inputs are expected to stay steady while a word is in flight.

Top module: `spi_cs_sequencer`

## Requirements
- R1: After reset, every chip-select line is high (all ones), and eng_start, busy, word_done, err_timeout and err_desync are all low.
- R2: While a word is framed, exactly one line is low: line n, where n is the binary value of word_idx captured at acceptance (bit n of cs_n). All other lines stay high.
- R3: With the timer-off control clear, eng_start rises exactly cfg_setup cycles after the cycle in which the line first goes low, and in the same cycle when cfg_setup is 0.
- R4: With wait mode off, the line returns high exactly cfg_hold+1 cycles after the cycle in which eng_done is sampled high. The keep control must be clear.
- R5: With cfg_timer_off set, both the setup delay and the hold delay are skipped, whatever cfg_setup and cfg_hold hold. The start happens in the select cycle, and release comes one cycle after done.
- R6: When word_gap_en was set at acceptance, word_done and readiness for the next word come cfg_gap cycles after the line is released. When it was clear, they come in the release cycle, whatever cfg_gap holds.
- R7: When word_keep was set at acceptance, the line stays low after the word and word_done still pulses. A following word on the same index starts the engine in its first cycle, with no setup delay. A following word on another index moves the selection and applies the setup delay. A word with keep clear releases the line.
- R8: In wait mode, eng_start is issued in the cycle after the first cycle in which slv_rdy_n is sampled low in the wait phase. This happens no earlier than after the setup delay.
- R9: In wait mode, the wait phase accepts ready through its first cfg_rdy_lead+CHAR_CLKS+1 cycles. If ready is still high at the last of these, err_timeout pulses one cycle later, no eng_start is issued, the keep request is dropped, the line is released after the hold delay, and word_done pulses.
- R10: In wait mode, after done the sequencer watches slv_rdy_n for up to cfg_rdy_trail+1 cycles. If ready goes high within them, the word closes with no flag. If it is still low at the last of them, err_desync pulses one cycle later and the word closes anyway.
- R11: word_start is ignored while busy is high, including during the gap. The selected line and the start count are left unchanged.
- R12: eng_start is a single-cycle pulse, issued once per accepted word and only while the selected line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all delays count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_start | input | 1 | Request a word; accepted only when busy is low |
| word_idx | input | IW | Chip-select line index for the word |
| word_keep | input | 1 | Keep the line low after this word |
| word_gap_en | input | 1 | Apply the inter-word gap after this word |
| cfg_setup | input | DW | Select-to-start delay, cycles |
| cfg_hold | input | DW | Done-to-release delay, cycles |
| cfg_rdy_lead | input | DW | Ready lead allowance, cycles |
| cfg_rdy_trail | input | DW | Ready trailing allowance, cycles |
| cfg_gap | input | GW | Inter-word gap, cycles |
| cfg_timer_off | input | 1 | Skip setup and hold delays |
| cfg_wait_en | input | 1 | Enable the slave-ready handshake |
| slv_rdy_n | input | 1 | Slave ready, active low |
| eng_done | input | 1 | Shift engine finished the word |
| eng_start | output | 1 | One-cycle start pulse to the shift engine |
| cs_n | output | NCS | Active-low chip-select lines |
| busy | output | 1 | A word is in progress; new requests are ignored |
| word_done | output | 1 | One-cycle pulse when a word is closed |
| err_timeout | output | 1 | One-cycle pulse: ready never arrived |
| err_desync | output | 1 | One-cycle pulse: ready stayed active after the word |

## Verification
The bench builds the block with eight lines, 8-bit delay fields, a 6-bit gap field and a character allowance of 6 cycles. The short allowance keeps the ready window at about a dozen cycles. That lets both the last-accepted-cycle boundary and the expired case be hit exactly. The full-width fields allow the 255-cycle setup and hold extremes and the 63-cycle gap to run within the cycle budget. All eight lines, including the highest index, can be selected.

// File: rtl/cs_seq_pkg.sv
package cs_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAITR,
    ST_FIRE,
    ST_XFER,
    ST_TRAIL,
    ST_HOLD,
    ST_GAP,
    ST_HELD
  } seq_st_e;

  // A phase of len cycles that began with cnt = 0 ends in the cycle where this is true.
  function automatic logic span_done(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) >= len;
  endfunction

  // Last wait-phase count value at which ready is still accepted.
  function automatic int unsigned ready_window(input int unsigned lead, input int unsigned char_clks);
    return lead + char_clks;
  endfunction

  // Width needed to count through the longest phase.
  function automatic int counter_width(input int dw, input int char_clks);
    return $clog2((1 << dw) + char_clks + 1);
  endfunction

endpackage

// File: rtl/cs_seq_counter.sv
module cs_seq_counter #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (clr)        q <= '0;
    else if (q != '1)    q <= q + 1'b1;
  end
endmodule

// File: rtl/cs_seq_decode.sv
module cs_seq_decode #(
  parameter int NCS = 8,
  localparam int IW = $clog2(NCS)
) (
  input  logic           active,
  input  logic [IW-1:0]  sel,
  output logic [NCS-1:0] cs_n
);
  for (genvar i = 0; i < NCS; i++) begin : g_line
    assign cs_n[i] = ~(active && (sel == IW'(i)));
  end
endmodule

// File: rtl/cs_seq_ctrl.sv
module cs_seq_ctrl
  import cs_seq_pkg::*;
#(
  parameter int NCS       = 8,
  parameter int DW        = 8,
  parameter int GW        = 6,
  parameter int CHAR_CLKS = 16,
  parameter int CW        = 9,
  localparam int IW       = $clog2(NCS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_start,
  input  logic [IW-1:0] word_idx,
  input  logic          word_keep,
  input  logic          word_gap_en,
  input  logic [DW-1:0] cfg_setup,
  input  logic [DW-1:0] cfg_hold,
  input  logic [DW-1:0] cfg_rdy_lead,
  input  logic [DW-1:0] cfg_rdy_trail,
  input  logic [GW-1:0] cfg_gap,
  input  logic          cfg_timer_off,
  input  logic          cfg_wait_en,
  input  logic          slv_rdy_n,
  input  logic          eng_done,
  input  logic [CW-1:0] cnt,
  output logic          cnt_clr,
  output logic          cs_active,
  output logic [IW-1:0] sel_idx,
  output logic          tout_ev,
  output logic          desync_ev,
  output logic          eng_start,
  output logic          busy,
  output logic          word_done,
  output logic          err_timeout,
  output logic          err_desync
);
  seq_st_e st, nxt;
  logic    keep_q, gap_q, take, fin, parked;
  logic    setup_on, hold_on, gap_on;
  seq_st_e pre_fire, after_release, after_word;

  assign parked   = (st == ST_IDLE) || (st == ST_HELD);
  assign take     = word_start && parked;
  assign setup_on = !cfg_timer_off && (cfg_setup != '0);
  assign hold_on  = !cfg_timer_off && (cfg_hold != '0);
  assign gap_on   = gap_q && (cfg_gap != '0);

  assign pre_fire      = cfg_wait_en ? ST_WAITR : ST_FIRE;
  assign after_release = gap_on ? ST_GAP : ST_IDLE;
  assign after_word    = keep_q ? (gap_on ? ST_GAP : ST_HELD)
                                : (hold_on ? ST_HOLD : after_release);

  always_comb begin
    nxt       = st;
    tout_ev   = 1'b0;
    desync_ev = 1'b0;
    unique case (st)
      ST_IDLE:  if (take) nxt = setup_on ? ST_SETUP : pre_fire;
      ST_HELD:  if (take) begin
                  if (word_idx == sel_idx) nxt = pre_fire;
                  else                     nxt = setup_on ? ST_SETUP : pre_fire;
                end
      ST_SETUP: if (span_done(32'(cnt), 32'(cfg_setup))) nxt = pre_fire;
      ST_WAITR: begin
                  if (!slv_rdy_n) nxt = ST_FIRE;
                  else if (32'(cnt) == ready_window(32'(cfg_rdy_lead), CHAR_CLKS)) begin
                    tout_ev = 1'b1;
                    nxt     = hold_on ? ST_HOLD : after_release;
                  end
                end
      ST_FIRE:  nxt = ST_XFER;
      ST_XFER:  if (eng_done) nxt = cfg_wait_en ? ST_TRAIL : after_word;
      ST_TRAIL: begin
                  if (slv_rdy_n) nxt = after_word;
                  else if (32'(cnt) == 32'(cfg_rdy_trail)) begin
                    desync_ev = 1'b1;
                    nxt       = after_word;
                  end
                end
      ST_HOLD:  if (span_done(32'(cnt), 32'(cfg_hold))) nxt = after_release;
      ST_GAP:   if (span_done(32'(cnt), 32'(cfg_gap))) nxt = keep_q ? ST_HELD : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign fin     = ((nxt == ST_IDLE) || (nxt == ST_HELD)) && !parked;
  assign cnt_clr = (nxt != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sel_idx     <= '0;
      keep_q      <= 1'b0;
      gap_q       <= 1'b0;
      word_done   <= 1'b0;
      err_timeout <= 1'b0;
      err_desync  <= 1'b0;
    end else begin
      st <= nxt;
      if (take) begin
        sel_idx <= word_idx;
        keep_q  <= word_keep;
        gap_q   <= word_gap_en;
      end else if (tout_ev) begin
        keep_q  <= 1'b0;
      end
      word_done   <= fin;
      err_timeout <= tout_ev;
      err_desync  <= desync_ev;
    end
  end

  assign eng_start = (st == ST_FIRE);
  assign busy      = !parked;
  assign cs_active = (st == ST_SETUP) || (st == ST_WAITR) || (st == ST_FIRE) ||
                     (st == ST_XFER)  || (st == ST_TRAIL) || (st == ST_HOLD) ||
                     (st == ST_HELD)  || ((st == ST_GAP) && keep_q);
endmodule

// File: rtl/spi_cs_sequencer.sv
module spi_cs_sequencer
  import cs_seq_pkg::*;
#(
  parameter int NCS       = 8,
  parameter int DW        = 8,
  parameter int GW        = 6,
  parameter int CHAR_CLKS = 16,
  localparam int IW       = $clog2(NCS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           word_start,
  input  logic [IW-1:0]  word_idx,
  input  logic           word_keep,
  input  logic           word_gap_en,
  input  logic [DW-1:0]  cfg_setup,
  input  logic [DW-1:0]  cfg_hold,
  input  logic [DW-1:0]  cfg_rdy_lead,
  input  logic [DW-1:0]  cfg_rdy_trail,
  input  logic [GW-1:0]  cfg_gap,
  input  logic           cfg_timer_off,
  input  logic           cfg_wait_en,
  input  logic           slv_rdy_n,
  input  logic           eng_done,
  output logic           eng_start,
  output logic [NCS-1:0] cs_n,
  output logic           busy,
  output logic           word_done,
  output logic           err_timeout,
  output logic           err_desync
);
  localparam int CW = counter_width(DW, CHAR_CLKS);

  // Internal events, named for the checker.
  logic          cnt_clr;
  logic [CW-1:0] phase_cnt;
  logic          cs_active;
  logic [IW-1:0] sel_idx;
  logic          tout_ev;
  logic          desync_ev;

  cs_seq_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .q     (phase_cnt)
  );

  cs_seq_ctrl #(
    .NCS(NCS), .DW(DW), .GW(GW), .CHAR_CLKS(CHAR_CLKS), .CW(CW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_start    (word_start),
    .word_idx      (word_idx),
    .word_keep     (word_keep),
    .word_gap_en   (word_gap_en),
    .cfg_setup     (cfg_setup),
    .cfg_hold      (cfg_hold),
    .cfg_rdy_lead  (cfg_rdy_lead),
    .cfg_rdy_trail (cfg_rdy_trail),
    .cfg_gap       (cfg_gap),
    .cfg_timer_off (cfg_timer_off),
    .cfg_wait_en   (cfg_wait_en),
    .slv_rdy_n     (slv_rdy_n),
    .eng_done      (eng_done),
    .cnt           (phase_cnt),
    .cnt_clr       (cnt_clr),
    .cs_active     (cs_active),
    .sel_idx       (sel_idx),
    .tout_ev       (tout_ev),
    .desync_ev     (desync_ev),
    .eng_start     (eng_start),
    .busy          (busy),
    .word_done     (word_done),
    .err_timeout   (err_timeout),
    .err_desync    (err_desync)
  );

  cs_seq_decode #(.NCS(NCS)) u_dec (
    .active (cs_active),
    .sel    (sel_idx),
    .cs_n   (cs_n)
  );
endmodule

// File: rtl/cs_seq_checker.sv
module cs_seq_checker #(
  parameter int NCS = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           eng_start,
  input logic           busy,
  input logic           word_done,
  input logic           err_timeout,
  input logic           cfg_wait_en,
  input logic           slv_rdy_n,
  input logic           tout_ev
);
  a_r2_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r12_start_selected: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (cs_n != '1));

  a_r8_ready_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_start && cfg_wait_en) |-> $past(!slv_rdy_n));

  a_r9_timeout_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    tout_ev |=> (err_timeout && !eng_start));

  a_r11_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cs_n != '1 && $past(cs_n) != '1) |-> $stable(cs_n));

  a_r6_done_parked: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> !busy);
endmodule

bind spi_cs_sequencer cs_seq_checker #(.NCS(NCS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .eng_start   (eng_start),
  .busy        (busy),
  .word_done   (word_done),
  .err_timeout (err_timeout),
  .cfg_wait_en (cfg_wait_en),
  .slv_rdy_n   (slv_rdy_n),
  .tout_ev     (tout_ev)
);

// File: tb/spi_cs_sequencer_bench.sv
module spi_cs_sequencer_bench;
  localparam int NCS = 8, DW = 8, GW = 6, CHARC = 6, IW = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, word_start, word_keep, word_gap_en, cfg_timer_off, cfg_wait_en;
  logic slv_rdy_n, eng_done;
  logic [IW-1:0] word_idx;
  logic [DW-1:0] cfg_setup, cfg_hold, cfg_rdy_lead, cfg_rdy_trail;
  logic [GW-1:0] cfg_gap;
  logic eng_start, busy, word_done, err_timeout, err_desync;
  logic [NCS-1:0] cs_n;

  spi_cs_sequencer #(.NCS(NCS), .DW(DW), .GW(GW), .CHAR_CLKS(CHARC)) u_spi_cs_sequencer (
    .clk(clk), .rst_n(rst_n), .word_start(word_start), .word_idx(word_idx),
    .word_keep(word_keep), .word_gap_en(word_gap_en), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_rdy_lead(cfg_rdy_lead), .cfg_rdy_trail(cfg_rdy_trail),
    .cfg_gap(cfg_gap), .cfg_timer_off(cfg_timer_off), .cfg_wait_en(cfg_wait_en),
    .slv_rdy_n(slv_rdy_n), .eng_done(eng_done), .eng_start(eng_start), .cs_n(cs_n),
    .busy(busy), .word_done(word_done), .err_timeout(err_timeout), .err_desync(err_desync)
  );

  int total = 0, bad = 0;
  int t_cs, t_st, n_st, t_dn, t_rel, t_wd, t_to, t_ds, cs_low, cs_wd;

  // idx, setup, hold, timer_off, gap_en, gap, exp setup span, exp hold span, exp gap span
  localparam int VT [7][9] = '{
    '{0,   3,   2, 0, 0,  5,   3,   3,  0},
    '{5,   0,   0, 0, 1,  4,   0,   1,  4},
    '{7,  10,   1, 1, 1,  0,   0,   1,  0},
    '{2,   1,   7, 0, 1,  2,   1,   8,  2},
    '{4,  20,   0, 0, 0,  9,  20,   1,  0},
    '{6,   4,   4, 1, 0,  9,   0,   1,  0},
    '{1, 255, 255, 0, 1, 63, 255, 256, 63}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int su, input int ho, input int toff, input int gap,
                         input int wait_en, input int lead, input int trail);
    cfg_setup = DW'(su); cfg_hold = DW'(ho); cfg_timer_off = toff[0];
    cfg_gap = GW'(gap); cfg_wait_en = wait_en[0];
    cfg_rdy_lead = DW'(lead); cfg_rdy_trail = DW'(trail);
  endtask

  // Issue one word; engine answers 3 cycles after start. Ready low from cycle rdy_at
  // (-1: never) until rdy_off cycles after done. poke: cycle of an extra request.
  task automatic run_word(input int idx, input bit keep, input bit gen,
                          input int rdy_at, input int rdy_off, input int poke);
    t_cs = -1; t_st = -1; n_st = 0; t_dn = -1; t_rel = -1; t_wd = -1;
    t_to = -1; t_ds = -1; cs_low = 255; cs_wd = 255;
    @(negedge clk);
    word_idx = IW'(idx); word_keep = keep; word_gap_en = gen; word_start = 1'b1;
    slv_rdy_n = 1'b1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk);
      word_start = (c == poke);
      word_idx   = (c == poke) ? IW'(0) : IW'(idx);
      if (cs_n != '1 && t_cs < 0) begin t_cs = c; cs_low = int'(cs_n); end
      if (t_cs >= 0 && cs_n == '1 && t_rel < 0) t_rel = c;
      if (eng_start) begin n_st++; if (t_st < 0) t_st = c; end
      if (err_timeout && t_to < 0) t_to = c;
      if (err_desync && t_ds < 0) t_ds = c;
      if (word_done) begin t_wd = c; cs_wd = int'(cs_n); break; end
      eng_done = (t_st >= 0 && c == t_st + 3);
      if (eng_done) t_dn = c;
      slv_rdy_n = !(rdy_at >= 0 && c >= rdy_at && (t_dn < 0 || c < t_dn + rdy_off));
    end
    eng_done = 1'b0; word_start = 1'b0; slv_rdy_n = 1'b1;
    check("R6", "word_done seen", int'(t_wd >= 0), 1);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; word_start = 1'b0; word_idx = '0; word_keep = 1'b0; word_gap_en = 1'b0;
    slv_rdy_n = 1'b1; eng_done = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cs_n", int'(cs_n), 255);
    check("R1", "outputs", int'({eng_start, busy, word_done, err_timeout, err_desync}), 0);

    // Table of plain words (wait mode off, keep off)
    for (int r = 0; r < 7; r++) begin
      set_cfg(VT[r][1], VT[r][2], VT[r][3], VT[r][5], 0, 0, 0);
      run_word(VT[r][0], 1'b0, VT[r][4][0], -1, 1, -1);
      check("R2", "selected line", cs_low, 255 ^ (1 << VT[r][0]));
      if (VT[r][3] != 0) begin
        check("R5", "setup span", t_st - t_cs, VT[r][6]);
        check("R5", "hold span", t_rel - t_dn, VT[r][7]);
      end else begin
        check("R3", "setup span", t_st - t_cs, VT[r][6]);
        check("R4", "hold span", t_rel - t_dn, VT[r][7]);
      end
      check("R6", "gap span", t_wd - t_rel, VT[r][8]);
      check("R12", "start count", n_st, 1);
    end

    // R8: ready present from the start, setup 2 -> start after one wait cycle
    set_cfg(2, 2, 0, 0, 1, 4, 3);
    run_word(3, 1'b0, 1'b0, 0, 1, -1);
    check("R8", "start with ready", t_st, 3);
    check("R10", "release after trail", t_rel - t_dn, 4);
    check("R10", "no desync", t_ds, -1);
    // R8: ready arrives late at cycle 7
    run_word(3, 1'b0, 1'b0, 7, 1, -1);
    check("R8", "start after late ready", t_st, 8);

    // R9 boundary: window = 4 + 6, wait phase from cycle 1, last accepted cycle 11
    set_cfg(1, 3, 0, 0, 1, 4, 3);
    run_word(2, 1'b0, 1'b0, 11, 1, -1);
    check("R9", "ready at last cycle starts", t_st, 12);
    check("R9", "no timeout at boundary", t_to, -1);
    // R9 expiry, with keep requested (must be dropped)
    run_word(2, 1'b1, 1'b0, -1, 1, -1);
    check("R9", "timeout cycle", t_to, 12);
    check("R9", "no start", n_st, 0);
    check("R9", "release after hold", t_rel, 15);
    check("R9", "line free at done", cs_wd, 255);

    // R10: ready stuck low after done, trail 3, setup 0, hold 0
    set_cfg(0, 0, 0, 0, 1, 4, 3);
    run_word(4, 1'b0, 1'b0, 0, 1000, -1);
    check("R10", "desync cycle", t_ds - t_dn, 5);
    check("R10", "release on desync", t_rel - t_dn, 5);
    // R10 boundary: ready goes high at the last watched cycle
    run_word(4, 1'b0, 1'b0, 0, 4, -1);
    check("R10", "no desync at boundary", t_ds, -1);
    check("R10", "release at boundary", t_rel - t_dn, 5);

    // R7: keep line low, then same index without setup
    set_cfg(3, 2, 0, 0, 0, 0, 0);
    run_word(3, 1'b1, 1'b0, -1, 1, -1);
    check("R7", "held after word", cs_wd, 255 ^ 8);
    check("R7", "not released", t_rel, -1);
    repeat (5) @(negedge clk);
    check("R7", "still held", int'(cs_n), 255 ^ 8);
    run_word(3, 1'b0, 1'b0, -1, 1, -1);
    check("R7", "same line skips setup", t_st, 0);
    check("R7", "final release", t_rel - t_dn, 3);
    // R7: held line moves to another index with setup applied
    run_word(3, 1'b1, 1'b0, -1, 1, -1);
    run_word(5, 1'b0, 1'b0, -1, 1, -1);
    check("R7", "new line selected", cs_low, 255 ^ 32);
    check("R7", "setup on line change", t_st, 3);
    @(negedge clk);
    check("R7", "released after last", int'(cs_n), 255);

    // R11: requests during transfer and during gap are ignored
    set_cfg(2, 1, 0, 3, 0, 0, 0);
    run_word(6, 1'b0, 1'b1, -1, 1, 4);
    check("R11", "line during busy", cs_low, 255 ^ 64);
    check("R11", "single start", n_st, 1);
    run_word(6, 1'b0, 1'b1, -1, 1, 8);
    check("R11", "gap kept", t_wd - t_rel, 3);
    repeat (4) @(negedge clk);
    check("R11", "no extra word", int'({busy, cs_n != '1, eng_start}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule